// File: doc/BRIEF.md
# VBUS Fault Protection Switch Sequencer

This block sequences the pass switch on a supply input. It takes digitised comparator flags for undervoltage, overvoltage and two die-temperature levels, plus an active-low enable. It drives a switch-enable output and an active-low acknowledge. Millisecond delays come from counting the free-running clock, and `CYC_PER_MS` sets how many clock cycles make one millisecond.

A supply fault opens the switch at once. The turn-on delay that follows depends on the most recent supply fault. A long qualification delay (17 ms) applies after power-up or after undervoltage. A short one (8 ms) applies after overvoltage. Over-temperature is latched: a hot flag sets it and a separate cool flag clears it. While over-temperature is latched, the switch stays open and acknowledge stays released.

All five inputs are asynchronous, so each passes through a two-flop synchronizer. Both outputs are registered.

Top module: `vbus_guard_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `sw_on` is 0 and `ack_n` is 1. Reset records the last supply fault as undervoltage.
- R2: After reset is released with all fault flags low, `en_n` low and `cool_raw` high, `sw_on` first goes to 1 exactly 17*CYC_PER_MS+3 rising clock edges after the release.
- R3: When `uv_raw` falls after an undervoltage fault, and no other fault is present, `sw_on` returns to 1 exactly 17*CYC_PER_MS+3 rising edges after the fall.
- R4: When `ov_raw` falls after an overvoltage-only fault, `sw_on` returns to 1 exactly 8*CYC_PER_MS+3 rising edges after the fall. If both flags were raised together, undervoltage takes precedence and the long delay applies.
- R5: When `uv_raw` or `ov_raw` rises, `sw_on` is 0 and `ack_n` is 1 from the third rising edge onward. They stay that way for as long as the flag is held.
- R6: If a supply fault reappears while a turn-on delay is counting, the count restarts from zero. The full delay is then measured from the final fall of the flag.
- R7: `en_n` is active low. With the supply qualified and no over-temperature, `sw_on` follows `!en_n` three rising edges after a change. `ack_n` does not depend on `en_n`.
- R8: `ack_n` is 0 exactly when the supply has been fault-free for the full turn-on delay and over-temperature is not latched. In every other case it is 1.
- R9: `hot_raw` high latches over-temperature: the switch opens and `ack_n` goes to 1. The latch holds after `hot_raw` falls, for as long as `cool_raw` is low. `cool_raw` high (die below the release temperature) clears the latch only while `hot_raw` is low.
- R10: When over-temperature clears and the supply has stayed qualified throughout, the switch closes (if `en_n` is low) and `ack_n` goes to 0 three edges later, with no new delay.
- R11: Any active fault flag forces `sw_on` to 0 whatever the state of `en_n` (truth-table priority). Input changes take effect through exactly two synchronizer flops plus one output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| uv_raw | input | 1 | Supply below undervoltage threshold (asynchronous) |
| ov_raw | input | 1 | Supply above overvoltage threshold (asynchronous) |
| hot_raw | input | 1 | Die above trip temperature (asynchronous) |
| cool_raw | input | 1 | Die below release temperature (asynchronous) |
| en_n | input | 1 | Active-low switch enable (asynchronous) |
| sw_on | output | 1 | Pass switch drive, 1 = closed |
| ack_n | output | 1 | Active-low supply-good acknowledge |

## Verification
The hardest situation to reach from the ports is a fault that comes back partway through a turn-on count. Such a fault must clear the count rather than pause it. To provoke it, the bench releases undervoltage, lets the count run well into its window, and then raises the flag again for two cycles. It then checks that closure happens a full long delay after the final release and not one cycle earlier. The choice between long and short delays is exercised the same way. The bench raises undervoltage and overvoltage together, then releases both, and confirms that the undervoltage delay wins.

// File: rtl/vgs_pkg.sv
package vgs_pkg;
  typedef enum logic {
    LAST_UV = 1'b0,
    LAST_OV = 1'b1
  } last_fault_t;

  localparam int unsigned LONG_MS_DEF  = 17;
  localparam int unsigned SHORT_MS_DEF = 8;
endpackage

// File: rtl/vgs_sync.sv
module vgs_sync #(
  parameter int unsigned     W       = 5,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/vgs_delay_timer.sv
module vgs_delay_timer #(
  parameter int unsigned CYC_PER_MS = 125000,
  parameter int unsigned LONG_MS    = 17,
  parameter int unsigned SHORT_MS   = 8,
  localparam int unsigned LONG_CYC  = LONG_MS * CYC_PER_MS,
  localparam int unsigned SHORT_CYC = SHORT_MS * CYC_PER_MS,
  localparam int unsigned CNT_W     = $clog2(LONG_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             use_short,
  output logic             ready,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] last_val;

  always_comb begin
    if (use_short) last_val = CNT_W'(SHORT_CYC - 1);
    else           last_val = CNT_W'(LONG_CYC - 1);
  end

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (!ready) begin
      if (cnt >= last_val) ready <= 1'b1;
      else                 cnt   <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/vbus_guard_seq.sv
module vbus_guard_seq #(
  parameter int unsigned CYC_PER_MS = 125000,
  parameter int unsigned LONG_MS    = vgs_pkg::LONG_MS_DEF,
  parameter int unsigned SHORT_MS   = vgs_pkg::SHORT_MS_DEF,
  localparam int unsigned LONG_CYC  = LONG_MS * CYC_PER_MS,
  localparam int unsigned CNT_W     = $clog2(LONG_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic uv_raw,
  input  logic ov_raw,
  input  logic hot_raw,
  input  logic cool_raw,
  input  logic en_n,
  output logic sw_on,
  output logic ack_n
);
  import vgs_pkg::*;

  // synchronized flags: {en_n, cool, hot, ov, uv}
  localparam int unsigned NFLAG = 5;
  localparam logic [NFLAG-1:0] SYNC_RST = 5'b1_0_0_0_1;

  logic [NFLAG-1:0] raw_vec, syn_vec;
  logic uv_q, ov_q, hot_q, cool_q, en_q;
  logic supply_bad;
  logic otp_q, otp_nxt;
  last_fault_t last_q;
  logic ready;
  logic [CNT_W-1:0] cnt;

  assign raw_vec = {en_n, cool_raw, hot_raw, ov_raw, uv_raw};

  vgs_sync #(.W(NFLAG), .RST_VAL(SYNC_RST)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_vec),
    .q   (syn_vec)
  );

  assign {en_q, cool_q, hot_q, ov_q, uv_q} = syn_vec;
  assign supply_bad = uv_q | ov_q;

  // over-temperature latch with two-level hysteresis; hot wins
  always_comb begin
    if (hot_q)       otp_nxt = 1'b1;
    else if (cool_q) otp_nxt = 1'b0;
    else             otp_nxt = otp_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      otp_q  <= 1'b0;
      last_q <= LAST_UV;
    end else begin
      otp_q <= otp_nxt;
      if (uv_q)      last_q <= LAST_UV;
      else if (ov_q) last_q <= LAST_OV;
    end
  end

  vgs_delay_timer #(
    .CYC_PER_MS (CYC_PER_MS),
    .LONG_MS    (LONG_MS),
    .SHORT_MS   (SHORT_MS)
  ) u_timer (
    .clk       (clk),
    .rst       (rst),
    .hold      (supply_bad),
    .use_short (last_q == LAST_OV),
    .ready     (ready),
    .cnt       (cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_on <= 1'b0;
      ack_n <= 1'b1;
    end else begin
      sw_on <= ready & ~supply_bad & ~otp_nxt & ~en_q;
      ack_n <= ~(ready & ~supply_bad & ~otp_nxt);
    end
  end
endmodule

// File: rtl/vgs_chk.sv
module vgs_chk #(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned LONG_CYC = 34
) (
  input logic             clk,
  input logic             rst,
  input logic             sw_on,
  input logic             ack_n,
  input logic             uv_q,
  input logic             ov_q,
  input logic             hot_q,
  input logic             cool_q,
  input logic             otp_q,
  input logic             ready,
  input logic [CNT_W-1:0] cnt
);
  // R5
  supply_fault_off_chk: assert property (@(posedge clk) disable iff (rst)
    (uv_q || ov_q) |=> (!sw_on && ack_n));

  // R6
  fault_clears_count_chk: assert property (@(posedge clk) disable iff (rst)
    (uv_q || ov_q) |=> (cnt == '0 && !ready));

  // R9
  otp_trip_chk: assert property (@(posedge clk) disable iff (rst)
    hot_q |=> otp_q);

  // R9
  otp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (otp_q && !cool_q) |=> otp_q);

  // R8
  closed_implies_ack_chk: assert property (@(posedge clk) disable iff (rst)
    sw_on |-> !ack_n);

  // R2
  close_after_delay_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sw_on) |-> $past(ready));

  // R6
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt < CNT_W'(LONG_CYC));
endmodule

bind vbus_guard_seq vgs_chk #(
  .CNT_W    (CNT_W),
  .LONG_CYC (LONG_CYC)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .sw_on  (sw_on),
  .ack_n  (ack_n),
  .uv_q   (uv_q),
  .ov_q   (ov_q),
  .hot_q  (hot_q),
  .cool_q (cool_q),
  .otp_q  (otp_q),
  .ready  (ready),
  .cnt    (cnt)
);

// File: tb/sim_vbus_guard_seq.sv
`timescale 1ns/1ps
module sim_vbus_guard_seq;
  localparam int unsigned C     = 2;
  localparam int unsigned LONGD = 17 * C + 3;
  localparam int unsigned SHRTD = 8 * C + 3;

  logic clk = 1'b0;
  logic rst, uv_raw, ov_raw, hot_raw, cool_raw, en_n;
  logic sw_on, ack_n;
  int   n_run = 0, n_fail = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  vbus_guard_seq #(.CYC_PER_MS(C)) u0 (
    .clk(clk), .rst(rst), .uv_raw(uv_raw), .ov_raw(ov_raw),
    .hot_raw(hot_raw), .cool_raw(cool_raw), .en_n(en_n),
    .sw_on(sw_on), .ack_n(ack_n)
  );

  task automatic chk(string req, logic got, logic exp, string what);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // checks that sw_on (and ack_n) change exactly at edge k after a stimulus
  task automatic rise_at(string req, int k, bit with_ack);
    edges(k - 1);
    chk(req, sw_on, 1'b0, "sw_on one edge early");
    if (with_ack) chk(req, ack_n, 1'b1, "ack_n one edge early");
    edges(1);
    chk(req, sw_on, 1'b1, "sw_on at edge");
    if (with_ack) chk(req, ack_n, 1'b0, "ack_n at edge");
  endtask

  task automatic fall_at(string req, int k);
    edges(k - 1);
    chk(req, sw_on, 1'b1, "sw_on before off edge");
    edges(1);
    chk(req, sw_on, 1'b0, "sw_on off");
    chk(req, ack_n, 1'b1, "ack_n released");
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; uv_raw = 1'b0; ov_raw = 1'b0; hot_raw = 1'b0;
    cool_raw = 1'b1; en_n = 1'b0;
    edges(4);
    chk("R1", sw_on, 1'b0, "sw_on in reset");
    chk("R1", ack_n, 1'b1, "ack_n in reset");
    rst = 1'b0;
    edges(1);
    chk("R1", sw_on, 1'b0, "sw_on after release");
    chk("R1", ack_n, 1'b1, "ack_n after release");
    // R2: power-up long qualification (one edge already consumed)
    rise_at("R2", LONGD - 1, 1'b1);

    // R7: enable toggles switch, ack unaffected
    en_n = 1'b1;
    edges(2);
    chk("R7", sw_on, 1'b1, "sw_on before en effect");
    edges(1);
    chk("R7", sw_on, 1'b0, "sw_on with en_n high");
    chk("R7", ack_n, 1'b0, "ack_n independent of en");
    en_n = 1'b0;
    edges(3);
    chk("R7", sw_on, 1'b1, "sw_on with en_n low");

    // R5, R11: undervoltage opens at edge 3; R3 long recovery
    uv_raw = 1'b1;
    fall_at("R5", 3);
    edges(10);
    chk("R5", sw_on, 1'b0, "held open during uv");
    uv_raw = 1'b0;
    rise_at("R3", LONGD, 1'b1);

    // R4: overvoltage short recovery
    ov_raw = 1'b1;
    fall_at("R11", 3);
    edges(6);
    ov_raw = 1'b0;
    rise_at("R4", SHRTD, 1'b1);

    // R4: both together -> undervoltage priority, long delay
    uv_raw = 1'b1; ov_raw = 1'b1;
    fall_at("R4", 3);
    edges(5);
    uv_raw = 1'b0; ov_raw = 1'b0;
    rise_at("R4", LONGD, 1'b1);

    // R6: fault reappears mid-count
    uv_raw = 1'b1;
    fall_at("R6", 3);
    edges(4);
    uv_raw = 1'b0;
    edges(20);
    chk("R6", sw_on, 1'b0, "mid-count still open");
    uv_raw = 1'b1;
    edges(2);
    uv_raw = 1'b0;
    rise_at("R6", LONGD, 1'b1);

    // R9: over-temperature latch with hysteresis; R10: release without delay
    hot_raw = 1'b1; cool_raw = 1'b0;
    fall_at("R9", 3);
    edges(5);
    hot_raw = 1'b0;
    edges(40);
    chk("R9", sw_on, 1'b0, "latched after hot falls");
    chk("R9", ack_n, 1'b1, "ack held while latched");
    cool_raw = 1'b1;
    rise_at("R10", 3, 1'b1);
    // R9: hot has priority over cool
    hot_raw = 1'b1;
    edges(10);
    chk("R9", sw_on, 1'b0, "hot overrides cool");
    chk("R9", ack_n, 1'b1, "ack with hot and cool");
    hot_raw = 1'b0;
    edges(3);
    chk("R10", sw_on, 1'b1, "reclosed after hot");

    // R8, R11: sweep of truth table with cool held high
    for (int i = 0; i < 16; i++) begin
      logic u, o, h, e;
      {e, h, o, u} = 4'(i);
      uv_raw = u; ov_raw = o; hot_raw = h; en_n = e;
      edges(LONGD + 8);
      chk("R11", sw_on, ~u & ~o & ~h & ~e, $sformatf("sweep sw_on combo %0d", i));
      chk("R8",  ack_n, u | o | h,         $sformatf("sweep ack_n combo %0d", i));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule